// File: doc/BRIEF.md
# Infrared Slow-Mode Bit-Rate Timer

This block generates the timing strobes for an infrared serial link running in its slow, asynchronous mode. The block runs from a 48 MHz system clock. A fixed prescaler slows that clock by a factor of 26. A programmable reload counter then divides the prescaled strobe by the stored count value plus one. The result is a 16x oversampling strobe for the receiver and transmitter shift logic. A final divide-by-16 stage turns the oversampling strobe into a once-per-bit strobe. The bit rate is therefore 48 MHz / 26 / (N + 1) / 16. To get a target rate, program N = 48 000 000 / 26 / 16 / rate − 1. For the default rate of 9600 bit/s, N is 11.

Control logic writes N into a 6-bit rate field. It can do so only while the link is in slow mode. In the faster modes, any write to the field is dropped. When the receiver times out, a dedicated strobe restores the 9600 bit/s value at once. A new value never cuts short a strobe period that is already running. It is picked up at the next reload of the counter.

Top module: `irbaud_gen`

## Requirements
- R1: The prescaler emits one enable every 26 clocks, so with N = 0 the oversampling strobe `os_tick_o` repeats every 26 clocks.
- R2: With rate field value N (the 6-bit value on `rate_wdata_i[5:0]`, read back on `rate_field_o[5:0]`), `os_tick_o` repeats every 26 × (N + 1) clocks for every N from 0 to 63.
- R3: `bit_tick_o` pulses once for every 16 pulses of `os_tick_o`. It goes high exactly one clock after the 16th oversampling pulse, giving a period of 416 × (N + 1) clocks.
- R4: `os_tick_o` and `bit_tick_o` are each high for exactly one clock per pulse.
- R5: A write (`rate_wr_i` = 1) updates the field only when `mode_i` = 2'b00 (slow mode). In modes 2'b01, 2'b10 and 2'b11 the write leaves the field and the strobe period unchanged.
- R6: A high `timeout_revert_i` sets the field to 11 on the next clock edge, whatever the mode. This takes priority over a write in the same cycle.
- R7: A new field value takes effect at the next counter reload. The strobe interval already running when the write lands finishes at its old length.
- R8: After reset the field holds 11, both strobes are low, and the oversampling strobe runs at the 9600 bit/s period of 312 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mode_i | input | 2 | Link mode: 2'b00 slow, 2'b01 medium, 2'b10 fast, 2'b11 off |
| rate_wr_i | input | 1 | Write strobe for the rate field |
| rate_wdata_i | input | 6 | New rate count value N |
| timeout_revert_i | input | 1 | Receive-timeout strobe that restores the 9600 bit/s count |
| rate_field_o | output | 6 | Current contents of the rate field |
| os_tick_o | output | 1 | 16x oversampling strobe, one clock wide |
| bit_tick_o | output | 1 | Bit-period strobe, one clock wide |

## Verification
The bench checks the divider at both extremes of the field. At N = 0 a reload counter with an off-by-one error would give 0 or 52 clocks instead of 26. At N = 63 a counter that truncates would wrap early.

A field write is placed just after a reload. A design that loads the new value into the running counter at once would produce a shortened interval where the old 312-clock one is expected.

Writes in each non-slow mode are checked for being dropped. A revert that arrives together with a write is checked for taking priority. A design with the wrong priority would leave the written value in the field.

The bit strobe is timed against the oversampling strobe. A divide-by-16 that counts the wrong edge would shift the strobe or make it 15 or 17 oversampling periods long.

// File: rtl/irbaud_pkg.sv
package irbaud_pkg;

  typedef enum logic [1:0] {
    LINK_SLOW = 2'b00,
    LINK_MED  = 2'b01,
    LINK_FAST = 2'b10,
    LINK_OFF  = 2'b11
  } link_mode_e;

  localparam int unsigned PRE_DIV_DFLT  = 26;
  localparam int unsigned RATE_W_DFLT   = 6;
  localparam int unsigned OVS_DFLT      = 16;
  localparam int unsigned SAFE_CNT_DFLT = 11;

endpackage

// File: rtl/irbaud_prescale.sv
module irbaud_prescale #(
  parameter int unsigned PRE_DIV = 26
) (
  input  logic clk,
  input  logic rst_n,
  output logic pre_en_o
);
  localparam int unsigned PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(PRE_DIV - 1);

  logic [PW-1:0] pre_cnt_q;
  logic [PW-1:0] pre_cnt_d;
  logic          at_last;

  always_comb begin
    at_last   = (pre_cnt_q == PRE_LAST);
    pre_cnt_d = at_last ? '0 : pre_cnt_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_cnt_q <= '0;
    else        pre_cnt_q <= pre_cnt_d;
  end

  assign pre_en_o = at_last;

  // enable pulses are isolated single cycles
  AST_PRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pre_en_o |=> !pre_en_o); // R1

endmodule

// File: rtl/irbaud_field.sv
module irbaud_field
  import irbaud_pkg::*;
#(
  parameter int unsigned RATE_W   = 6,
  parameter int unsigned SAFE_CNT = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  link_mode_e        mode_i,
  input  logic              wr_i,
  input  logic [RATE_W-1:0] wdata_i,
  input  logic              revert_i,
  output logic [RATE_W-1:0] field_o
);
  localparam logic [RATE_W-1:0] SAFE_VAL = RATE_W'(SAFE_CNT);

  logic [RATE_W-1:0] field_q;
  logic [RATE_W-1:0] field_d;
  logic              field_en;

  always_comb begin
    field_en = revert_i || (wr_i && (mode_i == LINK_SLOW));
    field_d  = revert_i ? SAFE_VAL : wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        field_q <= SAFE_VAL;
    else if (field_en) field_q <= field_d;
  end

  assign field_o = field_q;

  AST_REVERT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    revert_i |=> (field_o == SAFE_VAL)); // R6

  AST_FAST_WR_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !revert_i && mode_i != LINK_SLOW) |=> $stable(field_o)); // R5

endmodule

// File: rtl/irbaud_reload.sv
module irbaud_reload #(
  parameter int unsigned RATE_W   = 6,
  parameter int unsigned SAFE_CNT = 11,
  parameter int unsigned PRE_DIV  = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pre_en_i,
  input  logic [RATE_W-1:0] field_i,
  output logic              os_tick_o
);
  logic [RATE_W-1:0] cnt_q;
  logic [RATE_W-1:0] cnt_d;
  logic              tick_d;
  logic              tick_q;
  logic              at_zero;

  always_comb begin
    at_zero = (cnt_q == '0);
    tick_d  = pre_en_i && at_zero;
    cnt_d   = cnt_q;
    if (pre_en_i) cnt_d = at_zero ? field_i : cnt_q - RATE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= RATE_W'(SAFE_CNT);
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign os_tick_o = tick_q;

  // checker: spacing between oversampling strobes never drops below the prescaler period
  logic [15:0] gap_q;
  logic        seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (tick_q) begin
      gap_q  <= 16'd1;
      seen_q <= 1'b1;
    end else if (gap_q != 16'hFFFF) begin
      gap_q  <= gap_q + 16'd1;
    end
  end

  AST_OS_FROM_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    os_tick_o |-> $past(pre_en_i)); // R2

  AST_OS_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    os_tick_o |=> !os_tick_o); // R4

  AST_OS_NO_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (os_tick_o && seen_q) |-> (gap_q >= 16'(PRE_DIV))); // R7

endmodule

// File: rtl/irbaud_ovs.sv
module irbaud_ovs #(
  parameter int unsigned OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic os_tick_i,
  output logic bit_tick_o
);
  localparam int unsigned OW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [OW-1:0] OVS_LAST = OW'(OVS - 1);

  logic [OW-1:0] ovs_q;
  logic [OW-1:0] ovs_d;
  logic          bit_d;
  logic          bit_q;

  always_comb begin
    bit_d = os_tick_i && (ovs_q == OVS_LAST);
    ovs_d = ovs_q;
    if (os_tick_i) ovs_d = (ovs_q == OVS_LAST) ? '0 : ovs_q + OW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovs_q <= '0;
      bit_q <= 1'b0;
    end else begin
      ovs_q <= ovs_d;
      bit_q <= bit_d;
    end
  end

  assign bit_tick_o = bit_q;

  AST_BIT_AFTER_OS: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick_o |-> $past(os_tick_i)); // R3

  AST_BIT_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick_o |=> !bit_tick_o); // R4

endmodule

// File: rtl/irbaud_gen.sv
module irbaud_gen
  import irbaud_pkg::*;
#(
  parameter int unsigned PRE_DIV  = PRE_DIV_DFLT,
  parameter int unsigned RATE_W   = RATE_W_DFLT,
  parameter int unsigned OVS      = OVS_DFLT,
  parameter int unsigned SAFE_CNT = SAFE_CNT_DFLT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              rate_wr_i,
  input  logic [RATE_W-1:0] rate_wdata_i,
  input  logic              timeout_revert_i,
  output logic [RATE_W-1:0] rate_field_o,
  output logic              os_tick_o,
  output logic              bit_tick_o
);
  logic       rst_meta_q;
  logic       rst_sync_q;
  logic       pre_en;
  link_mode_e mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign mode = link_mode_e'(mode_i);

  irbaud_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .pre_en_o (pre_en)
  );

  irbaud_field #(.RATE_W(RATE_W), .SAFE_CNT(SAFE_CNT)) u_field (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .mode_i   (mode),
    .wr_i     (rate_wr_i),
    .wdata_i  (rate_wdata_i),
    .revert_i (timeout_revert_i),
    .field_o  (rate_field_o)
  );

  irbaud_reload #(.RATE_W(RATE_W), .SAFE_CNT(SAFE_CNT), .PRE_DIV(PRE_DIV)) u_reload (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .pre_en_i  (pre_en),
    .field_i   (rate_field_o),
    .os_tick_o (os_tick_o)
  );

  irbaud_ovs #(.OVS(OVS)) u_ovs (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .os_tick_i  (os_tick_o),
    .bit_tick_o (bit_tick_o)
  );

  AST_RESET_FIELD: assert property (@(posedge clk)
    (rst_sync_q && !$past(rst_sync_q)) |-> (rate_field_o == RATE_W'(SAFE_CNT))); // R8

endmodule

// File: tb/irbaud_gen_tb.sv
module irbaud_gen_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode;
  logic       wr;
  logic [5:0] wdata;
  logic       revert;
  logic [5:0] field;
  logic       os_tick;
  logic       bit_tick;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irbaud_gen dut_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .mode_i           (mode),
    .rate_wr_i        (wr),
    .rate_wdata_i     (wdata),
    .timeout_revert_i (revert),
    .rate_field_o     (field),
    .os_tick_o        (os_tick),
    .bit_tick_o       (bit_tick)
  );

  // {N, expected os period}
  localparam int NV = 5;
  localparam int VEC [NV][2] = '{
    '{0, 26}, '{1, 52}, '{5, 156}, '{63, 1664}, '{11, 312}
  };

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG) begin
      fails  = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WATCHDOG);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // advance negedges until os_tick seen; return cycles elapsed
  task automatic wait_os(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n = n + 1;
    end while (!os_tick);
  endtask

  task automatic wait_bit(output int n, output bit prev_os);
    bit last;
    n = 0;
    last = 1'b0;
    do begin
      last = os_tick;
      @(negedge clk);
      n = n + 1;
    end while (!bit_tick);
    prev_os = last;
  endtask

  task automatic write_rate(input logic [1:0] m, input logic [5:0] v);
    mode  = m;
    wr    = 1'b1;
    wdata = v;
    @(negedge clk);
    wr    = 1'b0;
  endtask

  initial begin
    int n;
    int wide;
    bit po;
    rst_n  = 1'b0;
    mode   = 2'b00;
    wr     = 1'b0;
    wdata  = '0;
    revert = 1'b0;
    repeat (4) @(negedge clk);
    // R8 reset state
    chk("R8 field at reset", field, 11);
    chk("R8 os low in reset", os_tick, 0);
    chk("R8 bit low in reset", bit_tick, 0);
    rst_n = 1'b1;
    wait_os(n);
    wait_os(n);
    chk("R8 default os period", n, 312);

    // R2/R1 vector table
    for (int i = 0; i < NV; i++) begin
      write_rate(2'b00, 6'(VEC[i][0]));
      chk("R2 field readback", field, VEC[i][0]);
      wait_os(n);
      wait_os(n);
      chk(VEC[i][0] == 0 ? "R1 prescale period" : "R2 os period", n, VEC[i][1]);
    end

    // R4 one-wide os pulse
    @(negedge clk);
    wide = os_tick;
    chk("R4 os pulse width", wide, 0);

    // R7 write just after a reload keeps the running interval
    wait_os(n);
    write_rate(2'b00, 6'd0);
    wait_os(n);
    chk("R7 running interval kept", n + 1, 312);
    wait_os(n);
    chk("R7 new value after reload", n, 26);

    // R3 bit tick with N=0
    wait_bit(n, po);
    wait_bit(n, po);
    chk("R3 bit period", n, 416);
    chk("R3 bit one cycle after os", po, 1);
    @(negedge clk);
    chk("R4 bit pulse width", bit_tick, 0);

    // R5 writes in other modes dropped
    for (int m = 1; m < 4; m++) begin
      write_rate(2'(m), 6'd40);
      chk("R5 write ignored in fast mode", field, 0);
    end
    mode = 2'b10;
    wait_os(n);
    wait_os(n);
    chk("R5 period unchanged", n, 26);

    // R6 revert in non-slow mode
    mode   = 2'b01;
    revert = 1'b1;
    @(negedge clk);
    revert = 1'b0;
    chk("R6 revert in other mode", field, 11);

    // R6 revert wins over simultaneous write
    write_rate(2'b00, 6'd7);
    chk("R6 setup write", field, 7);
    mode   = 2'b00;
    wr     = 1'b1;
    wdata  = 6'd40;
    revert = 1'b1;
    @(negedge clk);
    wr     = 1'b0;
    revert = 1'b0;
    chk("R6 revert priority", field, 11);
    wait_os(n);
    wait_os(n);
    chk("R6 period after revert", n, 312);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule